// File: doc/BRIEF.md
# Tiered Reset Distribution Controller

This block produces the individual reset outputs for the sub-modules of a two-port switch device: the Port 1 PHY, the Port 2 PHY, the virtual PHY, the host bus interface, the host MAC, the low-address system control registers and the remaining core logic. It merges a power-on reset, an active-low board reset pin and reset requests that software writes through the host register interface. Each request covers a fixed set of domains, and the requests fall into three tiers: a chip-wide tier that covers everything, a multi-domain tier, and a per-domain tier.

Every request that software writes is held internally for a fixed stretch of clock cycles. It reads back as set while it is active and clears itself when the stretch ends. A domain output asserts (goes low) as soon as any request covering it is active. It is released through a two-stage synchronizer on the system clock only after every covering request has ended. A chip-wide reset clears all pending software requests at once.

Top module: `rst_tier_ctrl`

## Requirements
- R1: While `por_n` or `ext_rst_n` is low, every reset output is low and both readback outputs are zero, with no clock edge needed. After both inputs go high, the outputs go high after exactly two rising clock edges, unless a software request is then active.
- R2: A write with `wr_sel`=0 (reset-control) and `wr_data[0]`=1 asserts the core, low-register, host-MAC and host-bus outputs. It leaves the three PHY outputs high.
- R3: A write with `wr_sel`=1 (hardware-config) and `wr_data[0]`=1 asserts only the host-bus, host-MAC and low-register outputs.
- R4: The Port 1 PHY output alone asserts on a write with `wr_sel`=0 and `wr_data[1]`=1, or with `wr_sel`=2 (Port 1 basic-control) and `wr_data[15]`=1.
- R5: The Port 2 PHY output alone asserts on a write with `wr_sel`=0 and `wr_data[2]`=1, or with `wr_sel`=3 (Port 2 basic-control) and `wr_data[15]`=1.
- R6: The virtual PHY output alone asserts on any of three writes: `wr_sel`=0 with `wr_data[3]`=1, `wr_sel`=5 (power-management control) with `wr_data[10]`=1, or `wr_sel`=4 (virtual PHY basic-control) with `wr_data[15]`=1.
- R7: After an accepted request, the outputs of the domains it covers go low on the next clock edge. They stay low for 18 cycles: 16 stretch cycles plus 2 synchronizer cycles.
- R8: A request's readback bit reads 1 for the 16 stretch cycles and then 0. The bits are `rb_ctl[0]` digital, `rb_ctl[1]` Port 1, `rb_ctl[2]` Port 2, `rb_ctl[3]` virtual PHY, and `rb_soft` soft.
- R9: When requests overlap, or a request is written again while it is active, a domain is released only 18 cycles after the last accepted write covering it.
- R10: A write changes no output and no readback bit if it uses a select code of 6 or 7, or sets only bits outside the request positions listed in R2 to R6.
- R11: A chip-wide reset during a software stretch cancels it. After release, the readback is 0 and all outputs go high after two edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | Board reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 3 | Target register code (0 reset-ctl, 1 hw-cfg, 2/3/4 Port1/Port2/virtual PHY basic-ctl, 5 power-mgmt) |
| wr_data | input | 16 | Write data |
| rb_ctl | output | 4 | Readback of reset-control request bits 3..0 |
| rb_soft | output | 1 | Readback of the soft reset request bit |
| rst_phy1_n | output | 1 | Port 1 PHY reset, active low |
| rst_phy2_n | output | 1 | Port 2 PHY reset, active low |
| rst_vphy_n | output | 1 | Virtual PHY reset, active low |
| rst_hbi_n | output | 1 | Host bus interface reset, active low |
| rst_hmac_n | output | 1 | Host MAC reset, active low |
| rst_lowcsr_n | output | 1 | Low-address system register reset, active low |
| rst_core_n | output | 1 | Remaining core logic reset, active low |

## Verification
Every request source is driven on its own through each register that can raise it. The full seven-bit output pattern is compared each time, so a wrong domain mapping for any request stands out from a correct one. The bench also writes several PHY bits in one write, and writes that touch only neutral bits or unused select codes; these separate bit decoding from register decoding. Staggered soft and digital requests, and a repeated Port 1 request, show whether release waits for the last covering request. A board reset in the middle of a stretch shows whether the chip-wide tier cancels software requests.

// File: rtl/rst_tier_pkg.sv
package rst_tier_pkg;

    // domain indices, in output vector order
    localparam int DOM_PHY1   = 0;
    localparam int DOM_PHY2   = 1;
    localparam int DOM_VPHY   = 2;
    localparam int DOM_HBI    = 3;
    localparam int DOM_HMAC   = 4;
    localparam int DOM_LOWCSR = 5;
    localparam int DOM_CORE   = 6;
    localparam int NDOM       = 7;

    // software request sources
    localparam int SRC_DIG  = 0;
    localparam int SRC_SOFT = 1;
    localparam int SRC_P1   = 2;
    localparam int SRC_P2   = 3;
    localparam int SRC_VP   = 4;
    localparam int NSRC     = 5;

    // bit positions inside the written registers
    localparam int RC_DIG_BIT  = 0;
    localparam int RC_P1_BIT   = 1;
    localparam int RC_P2_BIT   = 2;
    localparam int RC_VP_BIT   = 3;
    localparam int HW_SOFT_BIT = 0;
    localparam int BC_RST_BIT  = 15;
    localparam int PM_VP_BIT   = 10;

    typedef enum logic [2:0] {
        SEL_RSTCTL  = 3'd0,
        SEL_HWCFG   = 3'd1,
        SEL_P1_BC   = 3'd2,
        SEL_P2_BC   = 3'd3,
        SEL_VP_BC   = 3'd4,
        SEL_PMCTL   = 3'd5
    } reg_sel_e;

    // which domains a software source covers
    function automatic logic [NDOM-1:0] src_cover(input int src);
        logic [NDOM-1:0] m;
        m = '0;
        case (src)
            SRC_DIG: begin
                m[DOM_HBI] = 1'b1; m[DOM_HMAC] = 1'b1;
                m[DOM_LOWCSR] = 1'b1; m[DOM_CORE] = 1'b1;
            end
            SRC_SOFT: begin
                m[DOM_HBI] = 1'b1; m[DOM_HMAC] = 1'b1; m[DOM_LOWCSR] = 1'b1;
            end
            SRC_P1:  m[DOM_PHY1] = 1'b1;
            SRC_P2:  m[DOM_PHY2] = 1'b1;
            SRC_VP:  m[DOM_VPHY] = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rst_tier_decode.sv
module rst_tier_decode
    import rst_tier_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [NSRC-1:0] trig
);
    logic unused_data;
    assign unused_data = ^wr_data;

    always_comb begin
        trig = '0;
        if (wr_en) begin
            case (wr_sel)
                SEL_RSTCTL: begin
                    trig[SRC_DIG] = wr_data[RC_DIG_BIT];
                    trig[SRC_P1]  = wr_data[RC_P1_BIT];
                    trig[SRC_P2]  = wr_data[RC_P2_BIT];
                    trig[SRC_VP]  = wr_data[RC_VP_BIT];
                end
                SEL_HWCFG: trig[SRC_SOFT] = wr_data[HW_SOFT_BIT];
                SEL_P1_BC: trig[SRC_P1]   = wr_data[BC_RST_BIT];
                SEL_P2_BC: trig[SRC_P2]   = wr_data[BC_RST_BIT];
                SEL_VP_BC: trig[SRC_VP]   = wr_data[BC_RST_BIT];
                SEL_PMCTL: trig[SRC_VP]   = wr_data[PM_VP_BIT];
                default:   trig = '0;
            endcase
        end
    end
endmodule

// File: rtl/rst_tier_stretch.sv
module rst_tier_stretch #(
    parameter int STRETCH = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic trig,
    output logic busy
);
    localparam int CW = $clog2(STRETCH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d.cnt = CW'(STRETCH);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy = (st_q.cnt != '0);
endmodule

// File: rtl/rst_tier_sync.sv
module rst_tier_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold,
    output logic rst_n_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh = {st_q.sh[STAGES-2:0], ~hold};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    // assert from the request register at once, release via the chain
    assign rst_n_o = st_q.sh[STAGES-1] & ~hold;
endmodule

// File: rtl/rst_tier_ctrl.sv
module rst_tier_ctrl
    import rst_tier_pkg::*;
#(
    parameter int DW      = 16,
    parameter int STRETCH = 16,
    parameter int STAGES  = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ext_rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [3:0]    rb_ctl,
    output logic          rb_soft,
    output logic          rst_phy1_n,
    output logic          rst_phy2_n,
    output logic          rst_vphy_n,
    output logic          rst_hbi_n,
    output logic          rst_hmac_n,
    output logic          rst_lowcsr_n,
    output logic          rst_core_n
);
    logic            arst_n;
    logic [NSRC-1:0] trig;
    logic [NSRC-1:0] busy;
    logic [NDOM-1:0] hold;
    logic [NDOM-1:0] dom_rst_n;

    assign arst_n = por_n & ext_rst_n;

    rst_tier_decode #(.DW(DW)) u_dec (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .trig   (trig)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        rst_tier_stretch #(.STRETCH(STRETCH)) u_str (
            .clk   (clk),
            .arst_n(arst_n),
            .trig  (trig[s]),
            .busy  (busy[s])
        );
    end

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        always_comb begin
            hold[d] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (busy[s] && src_cover(s)[d]) hold[d] = 1'b1;
            end
        end

        rst_tier_sync #(.STAGES(STAGES)) u_sync (
            .clk    (clk),
            .arst_n (arst_n),
            .hold   (hold[d]),
            .rst_n_o(dom_rst_n[d])
        );
    end

    assign rb_ctl  = {busy[SRC_VP], busy[SRC_P2], busy[SRC_P1], busy[SRC_DIG]};
    assign rb_soft = busy[SRC_SOFT];

    assign rst_phy1_n   = dom_rst_n[DOM_PHY1];
    assign rst_phy2_n   = dom_rst_n[DOM_PHY2];
    assign rst_vphy_n   = dom_rst_n[DOM_VPHY];
    assign rst_hbi_n    = dom_rst_n[DOM_HBI];
    assign rst_hmac_n   = dom_rst_n[DOM_HMAC];
    assign rst_lowcsr_n = dom_rst_n[DOM_LOWCSR];
    assign rst_core_n   = dom_rst_n[DOM_CORE];
endmodule

// File: rtl/rst_tier_ctrl_chk.sv
module rst_tier_ctrl_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          por_n,
    input logic          ext_rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_sel,
    input logic [DW-1:0] wr_data,
    input logic [3:0]    rb_ctl,
    input logic          rb_soft,
    input logic          rst_phy1_n,
    input logic          rst_phy2_n,
    input logic          rst_vphy_n,
    input logic          rst_hbi_n,
    input logic          rst_hmac_n,
    input logic          rst_lowcsr_n,
    input logic          rst_core_n
);
    logic       chip_ok;
    logic [6:0] outs;
    assign chip_ok = por_n & ext_rst_n;
    assign outs = {rst_core_n, rst_lowcsr_n, rst_hmac_n, rst_hbi_n,
                   rst_vphy_n, rst_phy2_n, rst_phy1_n};

    a_r1_chip_all_low: assert property (@(negedge clk)
        !chip_ok |-> (outs == 7'd0 && rb_ctl == 4'd0 && !rb_soft));

    a_r2_digital_hits_core: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && wr_sel == 3'd0 && wr_data[0]) |=>
        (rb_ctl[0] && !rst_core_n && !rst_hbi_n && !rst_hmac_n && !rst_lowcsr_n));

    a_r3_soft_hits_host: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && wr_sel == 3'd1 && wr_data[0]) |=>
        (rb_soft && !rst_hbi_n && !rst_hmac_n && !rst_lowcsr_n));

    a_r4_phy1_sources: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && ((wr_sel == 3'd0 && wr_data[1]) || (wr_sel == 3'd2 && wr_data[15]))) |=>
        (rb_ctl[1] && !rst_phy1_n));

    a_r5_phy2_sources: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && ((wr_sel == 3'd0 && wr_data[2]) || (wr_sel == 3'd3 && wr_data[15]))) |=>
        (rb_ctl[2] && !rst_phy2_n));

    a_r6_vphy_sources: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && ((wr_sel == 3'd0 && wr_data[3]) || (wr_sel == 3'd5 && wr_data[10]) ||
                   (wr_sel == 3'd4 && wr_data[15]))) |=>
        (rb_ctl[3] && !rst_vphy_n));

    a_r7_sync_tail_after_soft: assert property (@(posedge clk) disable iff (!chip_ok)
        $fell(rb_soft) |-> !rst_hbi_n);

    a_r8_busy_means_low: assert property (@(posedge clk) disable iff (!chip_ok)
        rb_ctl[0] |-> !rst_core_n);

    a_r10_unused_sel_quiet: assert property (@(posedge clk) disable iff (!chip_ok)
        (wr_en && wr_sel > 3'd5 && rb_ctl == 4'd0 && !rb_soft) |=>
        (rb_ctl == 4'd0 && !rb_soft));
endmodule

bind rst_tier_ctrl rst_tier_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/rst_tier_ctrl_test.sv
module rst_tier_ctrl_test;

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] data;
        logic [6:0]  mask;   // domains expected low: {core,lowcsr,hmac,hbi,vphy,p2,p1}
        logic [3:0]  rbc;
        logic        rbs;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h0001, 7'b1111000, 4'b0001, 1'b0},  // R2 digital
        '{3'd1, 16'h0001, 7'b0111000, 4'b0000, 1'b1},  // R3 soft
        '{3'd0, 16'h0002, 7'b0000001, 4'b0010, 1'b0},  // R4 ctl bit
        '{3'd2, 16'h8000, 7'b0000001, 4'b0010, 1'b0},  // R4 basic-ctl
        '{3'd0, 16'h0004, 7'b0000010, 4'b0100, 1'b0},  // R5 ctl bit
        '{3'd3, 16'h8000, 7'b0000010, 4'b0100, 1'b0},  // R5 basic-ctl
        '{3'd0, 16'h0008, 7'b0000100, 4'b1000, 1'b0},  // R6 ctl bit
        '{3'd5, 16'h0400, 7'b0000100, 4'b1000, 1'b0},  // R6 power-mgmt
        '{3'd4, 16'h8000, 7'b0000100, 4'b1000, 1'b0},  // R6 basic-ctl
        '{3'd0, 16'h000E, 7'b0000111, 4'b1110, 1'b0},  // R4 R5 R6 together
        '{3'd0, 16'hFFF0, 7'b0000000, 4'b0000, 1'b0},  // R10 neutral bits
        '{3'd6, 16'hFFFF, 7'b0000000, 4'b0000, 1'b0},  // R10 unused select
        '{3'd2, 16'h7FFF, 7'b0000000, 4'b0000, 1'b0},  // R10 no bit 15
        '{3'd1, 16'hFFFE, 7'b0000000, 4'b0000, 1'b0}   // R10 no bit 0
    };

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  rb_ctl;
    logic        rb_soft;
    logic        rst_phy1_n, rst_phy2_n, rst_vphy_n, rst_hbi_n;
    logic        rst_hmac_n, rst_lowcsr_n, rst_core_n;
    logic [6:0]  outs;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rst_tier_ctrl uut (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rb_ctl(rb_ctl), .rb_soft(rb_soft),
        .rst_phy1_n(rst_phy1_n), .rst_phy2_n(rst_phy2_n), .rst_vphy_n(rst_vphy_n),
        .rst_hbi_n(rst_hbi_n), .rst_hmac_n(rst_hmac_n),
        .rst_lowcsr_n(rst_lowcsr_n), .rst_core_n(rst_core_n)
    );

    assign outs = {rst_core_n, rst_lowcsr_n, rst_hmac_n, rst_hbi_n,
                   rst_vphy_n, rst_phy2_n, rst_phy1_n};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input logic [6:0] exp, input string tag);
        chk(outs == exp, tag, 32'(outs), 32'(exp));
    endtask

    task automatic chk_rb(input logic [3:0] c, input logic s, input string tag);
        chk({rb_soft, rb_ctl} == {s, c}, tag, 32'({rb_soft, rb_ctl}), 32'({s, c}));
    endtask

    task automatic wr(input logic [2:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: power-on reset state and release timing
        tick(3);
        chk_outs(7'h00, "R1 por low");
        chk_rb(4'h0, 1'b0, "R1 readback in reset");
        por_n = 1'b1;
        tick(1);
        chk_outs(7'h00, "R1 one edge after release");
        tick(1);
        chk_outs(7'h7F, "R1 two edges after release");

        // table walk: R2..R8, R10
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].sel, VECS[i].data);
            chk_outs(~VECS[i].mask, "R2-6 vector assert");
            chk_rb(VECS[i].rbc, VECS[i].rbs, "R8 readback set");
            if (VECS[i].mask == 7'd0) begin
                tick(1);
                chk_outs(7'h7F, "R10 still idle");
                chk_rb(4'h0, 1'b0, "R10 readback idle");
            end else begin
                tick(15);
                chk_rb(VECS[i].rbc, VECS[i].rbs, "R8 readback last stretch cycle");
                tick(1);
                chk_rb(4'h0, 1'b0, "R8 readback self-clear");
                chk_outs(~VECS[i].mask, "R7 held in sync window");
                tick(1);
                chk_outs(~VECS[i].mask, "R7 cycle 17 low");
                tick(1);
                chk_outs(7'h7F, "R7 released at cycle 18");
            end
        end

        // R9: soft then digital, staggered
        wr(3'd1, 16'h0001);
        tick(7);
        wr(3'd0, 16'h0001);
        tick(9);
        chk_outs(7'b0000111, "R9 host domains held by digital");
        chk_rb(4'b0001, 1'b0, "R9 soft done digital busy");
        tick(8);
        chk_outs(7'b0000111, "R9 still held before digital end");
        tick(1);
        chk_outs(7'h7F, "R9 released after last request");

        // R9: retrigger Port 1 while active
        wr(3'd2, 16'h8000);
        tick(9);
        wr(3'd0, 16'h0002);
        tick(7);
        chk_outs(7'b1111110, "R9 retrigger keeps phy1 low");
        tick(10);
        chk_outs(7'b1111110, "R9 retrigger cycle 17 low");
        tick(1);
        chk_outs(7'h7F, "R9 retrigger released");

        // R11 / R1: board reset in the middle of a stretch
        wr(3'd0, 16'h0001);
        tick(4);
        #5 ext_rst_n = 1'b0;
        #1;
        chk_outs(7'h00, "R1 async assert on ext pin");
        chk_rb(4'h0, 1'b0, "R11 readback cleared by chip reset");
        @(negedge clk);
        ext_rst_n = 1'b1;
        tick(1);
        chk_rb(4'h0, 1'b0, "R11 readback stays clear");
        chk_outs(7'h00, "R11 sync window after pin release");
        tick(1);
        chk_outs(7'h7F, "R11 stretch cancelled");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule